// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block maps a 32-bit physical address from a console-style system bus onto one of several targets: main RAM at the bottom of the space, six device register windows, a 16 MiB flash window at the top of the space, and a 512-byte boot ROM. The boot ROM covers the highest addresses of the flash window. The flash device holds only 256 KiB, so its contents repeat across the whole window. For every request the block produces a one-hot region select and an offset relative to the start of the selected region. It also packs the byte lanes that the memory side returns into a read word in little-endian order.

A static variant strap selects the mapping. The retail mapping has 64 MiB of RAM and the boot ROM. The development mapping has 128 MiB of RAM and no boot ROM. A single-cycle kill pulse hides the boot ROM, and it stays hidden until the next reset. Once hidden, the top 512 bytes decode to flash. When a request falls into no region, the block returns zero data, sets a sticky error flag and keeps the first offending address.

Top module: `bootdec_top`

## Requirements
- R1: RAM is selected (select bit 0) with offset equal to the address for addresses below 0x04000000 when `dev_strap`=0, and below 0x08000000 when `dev_strap`=1.
- R2: The device windows are selected by bits 1..6 with offset = address − base: bit 1 0xFD000000–0xFDFFFFFF, bit 2 0xFE800000–0xFE87FFFF, bit 3 0xFEC00000–0xFEC00FFF, bit 4 0xFED00000–0xFED00FFF, bit 5 0xFED08000–0xFED08FFF, bit 6 0xFEF00000–0xFEF003FF.
- R3: Addresses 0xFF000000–0xFFFFFFFF that are not claimed by the boot ROM select flash (bit 7). The offset is the address modulo 256 KiB (address bits 17:0), so every 256 KiB mirror gives the same offset.
- R4: With `dev_strap`=0 and the boot ROM not killed, 0xFFFFFE00–0xFFFFFFFF select the boot ROM (bit 8) with offset = address bits 8:0, taking priority over flash.
- R5: With `dev_strap`=1 the boot ROM is never selected, and the top 512 bytes decode to flash.
- R6: A one-cycle `rom_kill` pulse makes every later request in the top 512 bytes decode to flash. The effect lasts until reset, and further pulses change nothing.
- R7: Any other address selects bit 9 (unmapped), with offset 0 and read data 0.
- R8: The first unmapped request sets `unmapped_err` and captures its address in `err_addr`. Both hold until reset, and later unmapped requests do not replace the address.
- R9: `req_size` 0 returns lane byte 0 zero-extended, 1 returns lanes 1:0 (lane 1 in bits 15:8), and 2 or 3 returns all four lanes with lane n in bits 8n+7:8n.
- R10: Select, offset and data appear one clock after a request is accepted, with `rsp_valid` high for that cycle. Without a request, `rsp_valid` is low and the outputs hold their values.
- R11: After reset, `rsp_valid`, `region_sel` and `unmapped_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_strap | input | 1 | 0 = retail mapping, 1 = development mapping |
| rom_kill | input | 1 | Pulse that hides the boot ROM until reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word |
| lane_data | input | 32 | Byte lanes for addr+0..addr+3 |
| rsp_valid | output | 1 | Response outputs updated |
| region_sel | output | 10 | One-hot region select |
| region_off | output | 32 | Region-relative offset |
| rdata | output | 32 | Packed read data |
| unmapped_err | output | 1 | Sticky unmapped-access flag |
| err_addr | output | 32 | First unmapped address |

## Verification
Each request's select, offset, data and error state are due at the first rising edge after the request is presented. The bench drives on the falling edge and compares against its reference model on the next falling edge. A kill pulse takes effect for requests presented after the edge that captures it, so the bench always issues the pulse in a cycle of its own. Internal reset release comes two edges after `rst_n` rises, and the bench waits three cycles before it checks the reset state.

// File: rtl/bootdec_pkg.sv
package bootdec_pkg;
  typedef logic [31:0] addr_t;

  localparam int NDEV     = 6;
  localparam int NREG     = NDEV + 4;
  localparam int RG_RAM   = 0;
  localparam int RG_DEV0  = 1;
  localparam int RG_FLASH = NDEV + 1;
  localparam int RG_ROM   = NDEV + 2;
  localparam int RG_NONE  = NDEV + 3;

  function automatic addr_t dev_base(int i);
    case (i)
      0:       return 32'hFD00_0000;
      1:       return 32'hFE80_0000;
      2:       return 32'hFEC0_0000;
      3:       return 32'hFED0_0000;
      4:       return 32'hFED0_8000;
      5:       return 32'hFEF0_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int dev_aw(int i);
    case (i)
      0:       return 24;
      1:       return 19;
      2:       return 12;
      3:       return 12;
      4:       return 12;
      5:       return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/bootdec_rst_sync.sv
module bootdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bootdec_region.sv
module bootdec_region
  import bootdec_pkg::*;
#(
  parameter int RETAIL_RAM_AW = 26,
  parameter int DEV_RAM_AW    = 27,
  parameter int FLASH_AW      = 18,
  parameter int FLASH_WIN_AW  = 24,
  parameter int ROM_AW        = 9
) (
  input  addr_t           addr,
  input  logic            dev_mode,
  input  logic            rom_en,
  output logic [NREG-1:0] sel,
  output addr_t           off
);
  localparam addr_t FLASH_MASK = (addr_t'(1) << FLASH_AW) - 1;
  localparam addr_t ROM_MASK   = (addr_t'(1) << ROM_AW) - 1;

  logic      ram_hit, rom_hit, flash_hit;
  logic [NDEV-1:0] dev_hit;
  addr_t     dev_off [NDEV];

  assign ram_hit   = dev_mode ? (addr[31:DEV_RAM_AW] == '0)
                              : (addr[31:RETAIL_RAM_AW] == '0);
  assign rom_hit   = rom_en && (&addr[31:ROM_AW]);
  assign flash_hit = &addr[31:FLASH_WIN_AW];

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    localparam int    AW   = dev_aw(g);
    localparam addr_t BASE = dev_base(g);
    localparam addr_t MASK = (addr_t'(1) << AW) - 1;
    assign dev_hit[g] = (addr[31:AW] == BASE[31:AW]);
    assign dev_off[g] = addr & MASK;
  end

  always_comb begin
    sel = '0;
    off = '0;
    if (ram_hit) begin
      sel[RG_RAM] = 1'b1;
      off         = addr;
    end else if (|dev_hit) begin
      for (int i = 0; i < NDEV; i++) begin
        if (dev_hit[i]) begin
          sel[RG_DEV0+i] = 1'b1;
          off            = dev_off[i];
        end
      end
    end else if (rom_hit) begin
      sel[RG_ROM] = 1'b1;
      off         = addr & ROM_MASK;
    end else if (flash_hit) begin
      sel[RG_FLASH] = 1'b1;
      off           = addr & FLASH_MASK;
    end else begin
      sel[RG_NONE] = 1'b1;
    end
  end
endmodule

// File: rtl/bootdec_rom_gate.sv
module bootdec_rom_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_mode,
  input  logic kill,
  output logic rom_en
);
  logic off_q, off_d;

  always_comb begin
    off_d = off_q;
    if (kill) off_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b0;
    else        off_q <= off_d;
  end

  assign rom_en = !dev_mode && !off_q;

  AST_ROM_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |=> off_q); // R6
endmodule

// File: rtl/bootdec_lane_pack.sv
module bootdec_lane_pack (
  input  logic [1:0]  size,
  input  logic [31:0] lanes,
  input  logic        zero,
  output logic [31:0] data
);
  always_comb begin
    case (size)
      2'd0:    data = {24'h0, lanes[7:0]};
      2'd1:    data = {16'h0, lanes[15:8], lanes[7:0]};
      default: data = {lanes[31:24], lanes[23:16], lanes[15:8], lanes[7:0]};
    endcase
    if (zero) data = '0;
  end
endmodule

// File: rtl/bootdec_top.sv
module bootdec_top
  import bootdec_pkg::*;
#(
  parameter int RETAIL_RAM_AW = 26,
  parameter int DEV_RAM_AW    = 27,
  parameter int FLASH_AW      = 18,
  parameter int ROM_AW        = 9,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_strap,
  input  logic            rom_kill,
  input  logic            req_valid,
  input  logic [31:0]     req_addr,
  input  logic [1:0]      req_size,
  input  logic [31:0]     lane_data,
  output logic            rsp_valid,
  output logic [NREG-1:0] region_sel,
  output logic [31:0]     region_off,
  output logic [31:0]     rdata,
  output logic            unmapped_err,
  output logic [31:0]     err_addr
);
  logic            rst_ns;
  logic            rom_en;
  logic [NREG-1:0] dec_sel;
  addr_t           dec_off;
  logic [31:0]     packed_data;

  bootdec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  bootdec_rom_gate u_gate (
    .clk(clk), .rst_n(rst_ns), .dev_mode(dev_strap), .kill(rom_kill), .rom_en(rom_en));

  bootdec_region #(
    .RETAIL_RAM_AW(RETAIL_RAM_AW), .DEV_RAM_AW(DEV_RAM_AW),
    .FLASH_AW(FLASH_AW), .FLASH_WIN_AW(24), .ROM_AW(ROM_AW)
  ) u_dec (
    .addr(req_addr), .dev_mode(dev_strap), .rom_en(rom_en), .sel(dec_sel), .off(dec_off));

  bootdec_lane_pack u_pack (
    .size(req_size), .lanes(lane_data), .zero(dec_sel[RG_NONE]), .data(packed_data));

  logic            vld_q, vld_d;
  logic [NREG-1:0] sel_q, sel_d;
  addr_t           off_q, off_d;
  logic [31:0]     data_q, data_d;
  logic            err_q, err_d;
  addr_t           eaddr_q, eaddr_d;

  always_comb begin
    vld_d   = req_valid;
    sel_d   = sel_q;
    off_d   = off_q;
    data_d  = data_q;
    err_d   = err_q;
    eaddr_d = eaddr_q;
    if (req_valid) begin
      sel_d  = dec_sel;
      off_d  = dec_off;
      data_d = packed_data;
      if (dec_sel[RG_NONE] && !err_q) begin
        err_d   = 1'b1;
        eaddr_d = req_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q   <= 1'b0;
      sel_q   <= '0;
      off_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      eaddr_q <= '0;
    end else begin
      vld_q   <= vld_d;
      sel_q   <= sel_d;
      off_q   <= off_d;
      data_q  <= data_d;
      err_q   <= err_d;
      eaddr_q <= eaddr_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign region_sel   = sel_q;
  assign region_off   = off_q;
  assign rdata        = data_q;
  assign unmapped_err = err_q;
  assign err_addr     = eaddr_q;

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> $countones(region_sel) == 1); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> !rsp_valid && $stable(region_sel) && $stable(region_off)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid && region_sel[RG_NONE] |-> rdata == '0 && region_off == '0); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ns)
    unmapped_err |=> unmapped_err && $stable(err_addr)); // R8
  AST_DEV_NO_ROM: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid && dev_strap |-> !region_sel[RG_ROM]); // R5
endmodule

// File: tb/tb_bootdec_top.sv
module tb_bootdec_top;
  logic        clk = 1'b0;
  logic        rst_n, dev_strap, rom_kill, req_valid;
  logic [31:0] req_addr, lane_data;
  logic [1:0]  req_size;
  logic        rsp_valid, unmapped_err;
  logic [9:0]  region_sel;
  logic [31:0] region_off, rdata, err_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_off;
  bit          m_err;
  logic [31:0] m_eaddr;

  always #5 clk = ~clk;

  bootdec_top dut (
    .clk(clk), .rst_n(rst_n), .dev_strap(dev_strap), .rom_kill(rom_kill),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .lane_data(lane_data), .rsp_valid(rsp_valid), .region_sel(region_sel),
    .region_off(region_off), .rdata(rdata), .unmapped_err(unmapped_err),
    .err_addr(err_addr));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: returns region index and offset
  function automatic int ref_region(logic [31:0] a, bit dev, bit killed, output logic [31:0] o);
    logic [31:0] lim = dev ? 32'h0800_0000 : 32'h0400_0000;
    o = 32'h0;
    if (a < lim) begin o = a; return 0; end
    if (a >= 32'hFD00_0000 && a <= 32'hFDFF_FFFF) begin o = a - 32'hFD00_0000; return 1; end
    if (a >= 32'hFE80_0000 && a <= 32'hFE87_FFFF) begin o = a - 32'hFE80_0000; return 2; end
    if (a >= 32'hFEC0_0000 && a <= 32'hFEC0_0FFF) begin o = a - 32'hFEC0_0000; return 3; end
    if (a >= 32'hFED0_0000 && a <= 32'hFED0_0FFF) begin o = a - 32'hFED0_0000; return 4; end
    if (a >= 32'hFED0_8000 && a <= 32'hFED0_8FFF) begin o = a - 32'hFED0_8000; return 5; end
    if (a >= 32'hFEF0_0000 && a <= 32'hFEF0_03FF) begin o = a - 32'hFEF0_0000; return 6; end
    if (!dev && !killed && a >= 32'hFFFF_FE00) begin o = a - 32'hFFFF_FE00; return 8; end
    if (a >= 32'hFF00_0000) begin o = (a - 32'hFF00_0000) % 32'h0004_0000; return 7; end
    return 9;
  endfunction

  task automatic do_reset(bit dev);
    rst_n = 1'b0; dev_strap = dev; rom_kill = 1'b0; req_valid = 1'b0;
    req_addr = '0; req_size = '0; lane_data = '0;
    m_off = 0; m_err = 0; m_eaddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R11 region_sel", {22'h0, region_sel}, 32'h0);
    check("R11 unmapped_err", {31'h0, unmapped_err}, 32'h0);
  endtask

  task automatic req(logic [31:0] a, logic [1:0] sz);
    logic [31:0] eo, ed, lanes;
    int          r;
    string       tag;
    lanes = a ^ 32'hA5C3_1E77;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; lane_data = lanes;
    r = ref_region(a, dev_strap, m_off, eo);
    case (sz)
      2'd0:    ed = lanes & 32'hFF;
      2'd1:    ed = lanes & 32'hFFFF;
      default: ed = lanes;
    endcase
    if (r == 9) begin
      ed = 0;
      if (!m_err) begin m_err = 1; m_eaddr = a; end
    end
    case (r)
      0:       tag = "R1";
      7:       tag = (dev_strap && a >= 32'hFFFF_FE00) ? "R5" : (m_off && a >= 32'hFFFF_FE00) ? "R6" : "R3";
      8:       tag = "R4";
      9:       tag = "R7";
      default: tag = "R2";
    endcase
    @(negedge clk);
    check("R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check({tag, " sel"}, {22'h0, region_sel}, 32'h1 << r);
    check({tag, " off"}, region_off, eo);
    check((r == 9) ? "R7 rdata" : "R9 rdata", rdata, ed);
    check("R8 err", {31'h0, unmapped_err}, {31'h0, m_err});
    check("R8 err_addr", err_addr, m_eaddr);
    req_valid = 1'b0;
  endtask

  task automatic idle_check();
    logic [9:0]  s = region_sel;
    logic [31:0] o = region_off;
    @(negedge clk);
    check("R10 idle valid", {31'h0, rsp_valid}, 32'h0);
    check("R10 idle hold sel", {22'h0, region_sel}, {22'h0, s});
    check("R10 idle hold off", region_off, o);
  endtask

  task automatic kill();
    @(negedge clk);
    rom_kill = 1'b1;
    @(negedge clk);
    rom_kill = 1'b0;
    m_off = 1;
  endtask

  task automatic sweep();
    logic [31:0] list [29] = '{
      32'h0000_0000, 32'h03FF_FFFF, 32'h0400_0000, 32'h07FF_FFFF, 32'h0800_0000,
      32'hFCFF_FFFF, 32'hFD00_0000, 32'hFDFF_FFFF, 32'hFE7F_FFFF, 32'hFE80_0000,
      32'hFE87_FFFF, 32'hFE88_0000, 32'hFEC0_0000, 32'hFEC0_0FFF, 32'hFEC0_1000,
      32'hFED0_0000, 32'hFED0_0FFF, 32'hFED0_8000, 32'hFED0_8FFF, 32'hFED0_9000,
      32'hFEF0_0000, 32'hFEF0_03FF, 32'hFEF0_0400, 32'hFF00_0000, 32'hFF04_0123,
      32'hFF87_FFFF, 32'hFFFF_FDFF, 32'hFFFF_FE00, 32'hFFFF_FFFF};
    for (int i = 0; i < 29; i++) req(list[i], 2'(i % 4));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // retail variant
    do_reset(1'b0);
    idle_check();
    sweep();
    idle_check();
    req(32'hFFC3_0044, 2'd2);  // R3 mirror
    req(32'hFFFF_FE10, 2'd1);  // R4 before kill
    kill();
    req(32'hFFFF_FE00, 2'd2);  // R6 falls to flash
    req(32'hFFFF_FFFF, 2'd0);
    kill();                    // R6 second pulse no change
    req(32'hFFFF_FF80, 2'd1);
    req(32'h1234_5678, 2'd3);  // R8 later unmapped keeps first addr
    // reset restores the boot ROM
    do_reset(1'b0);
    req(32'hFFFF_FE00, 2'd2);  // R4 after reset
    // development variant
    do_reset(1'b1);
    sweep();
    kill();
    req(32'hFFFF_FE04, 2'd2);  // R5
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule